// File: doc/BRIEF.md
# Sensor Event Interrupt Generator

This block watches a set of live sensor readings and a set of derived function results. It raises an interrupt towards the host processor when a programmed condition on one of those values becomes true. The host sets up one or more event slots and can then leave the values alone. It does not need to poll them. When the interrupt arrives, it reads the pending vector to find which slot fired.

Each slot picks its own source at run time, either one raw sensor channel or one function result. It also picks a comparison. The comparison is either a test against a single threshold (below, above, equal) or a window test against a lower and an upper bound (inside or outside). An event is recorded as pending on the cycle in which its condition turns true. It stays pending until the host acknowledges it by writing ones to the pending bits it wants cleared.

Top module: `sev_irq_gen`

## Requirements
- R1: While reset is held and after it is released, every pending bit is 0, `irq` is 0, and every slot is disabled with both bounds at 0.
- R2: A write with `cfg_we` high updates slot `cfg_slot` at the clock edge and takes effect from the next cycle. `cfg_sel`=0 writes the control word: bits [2:0] are the mode, bit 3 is the source type (0 sensor, 1 function), and bits [6:4] are the channel index. `cfg_sel`=1 writes the threshold, which is also the lower bound. `cfg_sel`=2 writes the upper bound. `cfg_sel`=3 changes nothing.
- R3: Mode 001 is true when value < threshold, mode 010 when value > threshold, and mode 011 when value == threshold. All values and thresholds are compared as two's-complement signed numbers.
- R4: Mode 100 is true when lower <= value <= upper, both ends included. Mode 101 is true when value < lower or value > upper.
- R5: With source type 0 the slot uses sensor channel `index` from `sens_vals` (channel k in bits [k*DW +: DW]). With source type 1 it uses function result `index` from `func_vals`, packed the same way.
- R6: A pending bit is set at the edge that follows a cycle in which its condition is true while it was false in the cycle before. A condition that stays true sets the bit only once. Without an acknowledge, a pending bit never clears. A condition that is already true right after reset counts as a rising one.
- R7: With `ack_we` high, every pending bit whose `ack_mask` bit is 1 is cleared at that edge. The other bits are untouched.
- R8: When a rising condition and an acknowledge of the same bit fall in the same cycle, the bit is left set.
- R9: `irq` is 1 exactly when some pending bit belongs to a slot whose mode is 001 to 101. A slot switched to a disabled mode keeps its pending bit, but that bit no longer drives `irq`.
- R10: Modes 000, 110 and 111 disable a slot. A disabled slot's condition is false, so it never sets its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sens_vals | input | NUM_CH*DW | Raw sensor values, channel k in bits [k*DW +: DW] |
| func_vals | input | NUM_CH*DW | Computed function results, same packing |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | SLOT_W | Slot addressed by the write |
| cfg_sel | input | 2 | Field: 0 control, 1 threshold/lower, 2 upper, 3 none |
| cfg_wdata | input | DW | Write data |
| ack_we | input | 1 | Acknowledge strobe |
| ack_mask | input | NUM_SLOTS | Write-one-to-clear mask for pending bits |
| pending | output | NUM_SLOTS | Pending event bits |
| irq | output | 1 | Interrupt request to the host |

## Verification
The edge detector that sets a pending bit and the host's write-one-to-clear can hit the same bit in the same cycle. The bench provokes this on purpose. It drives a slot's source out of its condition for one cycle and back in the next, and raises the acknowledge for that slot in the second cycle. It expects the bit to survive. A plain acknowledge of a condition that is held true is run as the contrast case, where the bit must clear and stay clear. A behavioural model in the bench applies the clear first and then the set, and the bench compares the pending vector and `irq` against it on every clock.

// File: rtl/sev_pkg.sv
package sev_pkg;

    localparam int IDX_W  = 3;
    localparam int NUM_CH = 1 << IDX_W;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        CMP_OFF = 3'd0,
        CMP_LT  = 3'd1,
        CMP_GT  = 3'd2,
        CMP_EQ  = 3'd3,
        CMP_IN  = 3'd4,
        CMP_OUT = 3'd5
    } cmp_mode_e;

    typedef enum logic [1:0] {
        FLD_CTRL = 2'd0,
        FLD_LO   = 2'd1,
        FLD_HI   = 2'd2,
        FLD_NONE = 2'd3
    } cfg_fld_e;

    // control word layout: {index, source type, mode}
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             from_func;
        cmp_mode_e        mode;
    } slot_ctrl_t;

    localparam int CTRL_W = $bits(slot_ctrl_t);

    function automatic logic mode_active(cmp_mode_e m);
        return (m == CMP_LT) || (m == CMP_GT) || (m == CMP_EQ) ||
               (m == CMP_IN) || (m == CMP_OUT);
    endfunction

endpackage

// File: rtl/sev_src_sel.sv
module sev_src_sel
    import sev_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [NUM_CH*DW-1:0] sens_flat,
    input  logic [NUM_CH*DW-1:0] func_flat,
    input  logic                 from_func,
    input  logic [IDX_W-1:0]     idx,
    output logic signed [DW-1:0] value
);

    logic [DW-1:0] sens_pick;
    logic [DW-1:0] func_pick;

    always_comb begin
        sens_pick = sens_flat[idx*DW +: DW];
        func_pick = func_flat[idx*DW +: DW];
        value     = from_func ? signed'(func_pick) : signed'(sens_pick);
    end

endmodule

// File: rtl/sev_cond_eval.sv
module sev_cond_eval
    import sev_pkg::*;
#(
    parameter int DW = 16
) (
    input  cmp_mode_e            mode,
    input  logic signed [DW-1:0] value,
    input  logic signed [DW-1:0] lo,
    input  logic signed [DW-1:0] hi,
    output logic                 hit
);

    logic below_lo;
    logic above_lo;
    logic above_hi;

    always_comb begin
        below_lo = value < lo;
        above_lo = value > lo;
        above_hi = value > hi;
        case (mode)
            CMP_LT:  hit = below_lo;
            CMP_GT:  hit = above_lo;
            CMP_EQ:  hit = (value == lo);
            CMP_IN:  hit = !below_lo && !above_hi;
            CMP_OUT: hit = below_lo || above_hi;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/sev_slot.sv
module sev_slot
    import sev_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  cfg_fld_e             wr_fld,
    input  logic [DW-1:0]        wr_data,
    input  logic                 hit,
    input  logic                 clr,
    output slot_ctrl_t           ctrl,
    output logic signed [DW-1:0] lo,
    output logic signed [DW-1:0] hi,
    output logic                 armed,
    output logic                 pend,
    output logic                 active
);

    logic rise;

    always_comb begin
        rise   = hit && !armed;
        active = mode_active(ctrl.mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '{idx: '0, from_func: 1'b0, mode: CMP_OFF};
            lo    <= '0;
            hi    <= '0;
            armed <= 1'b0;
            pend  <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_fld)
                    FLD_CTRL: ctrl <= slot_ctrl_t'(wr_data[CTRL_W-1:0]);
                    FLD_LO:   lo   <= signed'(wr_data);
                    FLD_HI:   hi   <= signed'(wr_data);
                    default:  ;
                endcase
            end
            armed <= hit;
            // clear first, then a new rise sets it again
            pend  <= (pend && !clr) || rise;
        end
    end

endmodule

// File: rtl/sev_irq_gen.sv
module sev_irq_gen
    import sev_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int DW        = 16,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH*DW-1:0]  sens_vals,
    input  logic [NUM_CH*DW-1:0]  func_vals,
    input  logic                  cfg_we,
    input  logic [SLOT_W-1:0]     cfg_slot,
    input  logic [1:0]            cfg_sel,
    input  logic [DW-1:0]         cfg_wdata,
    input  logic                  ack_we,
    input  logic [NUM_SLOTS-1:0]  ack_mask,
    output logic [NUM_SLOTS-1:0]  pending,
    output logic                  irq
);

    logic [NUM_SLOTS-1:0] hit_vec;
    logic [NUM_SLOTS-1:0] armed_vec;
    logic [NUM_SLOTS-1:0] en_vec;
    cfg_fld_e             fld;

    assign fld = cfg_fld_e'(cfg_sel);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        slot_ctrl_t           ctrl;
        logic signed [DW-1:0] lo;
        logic signed [DW-1:0] hi;
        logic signed [DW-1:0] value;
        logic                 wr_en;
        logic                 clr;

        assign wr_en = cfg_we && (cfg_slot == SLOT_W'(s));
        assign clr   = ack_we && ack_mask[s];

        sev_src_sel #(.DW(DW)) u_src (
            .sens_flat (sens_vals),
            .func_flat (func_vals),
            .from_func (ctrl.from_func),
            .idx       (ctrl.idx),
            .value     (value)
        );

        sev_cond_eval #(.DW(DW)) u_eval (
            .mode  (ctrl.mode),
            .value (value),
            .lo    (lo),
            .hi    (hi),
            .hit   (hit_vec[s])
        );

        sev_slot #(.DW(DW)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_fld  (fld),
            .wr_data (cfg_wdata),
            .hit     (hit_vec[s]),
            .clr     (clr),
            .ctrl    (ctrl),
            .lo      (lo),
            .hi      (hi),
            .armed   (armed_vec[s]),
            .pend    (pending[s]),
            .active  (en_vec[s])
        );
    end

    assign irq = |(pending & en_vec);

endmodule

// File: rtl/sev_irq_gen_chk.sv
module sev_irq_gen_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         ack_we,
    input logic [N-1:0] ack_mask,
    input logic [N-1:0] pending,
    input logic         irq,
    input logic [N-1:0] hit_vec,
    input logic [N-1:0] armed_vec,
    input logic [N-1:0] en_vec
);

    logic         rst_q = 1'b0;
    logic [N-1:0] rise_vec;

    always_ff @(posedge clk) rst_q <= rst;
    assign rise_vec = hit_vec & ~armed_vec;

    a_r1_reset_clear: assert property (@(posedge clk)
        rst_q |-> (pending == '0 && !irq));

    a_r6_set_needs_rise: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pending & ~$past(pending) & ~$past(rise_vec)) == '0));

    a_r6_hold_without_ack: assert property (@(posedge clk) disable iff (rst)
        !ack_we |=> ((pending & $past(pending)) == $past(pending)));

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        ack_we |=> ((pending & $past(ack_mask) & ~$past(rise_vec)) == '0));

    a_r8_rise_wins: assert property (@(posedge clk) disable iff (rst)
        (rise_vec != '0) |=> ((pending & $past(rise_vec)) == $past(rise_vec)));

    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        ((pending & en_vec) == '0) |-> !irq);

    a_r10_off_never_hits: assert property (@(posedge clk) disable iff (rst)
        ((hit_vec & ~en_vec) == '0));

endmodule

bind sev_irq_gen sev_irq_gen_chk #(.N(NUM_SLOTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack_we    (ack_we),
    .ack_mask  (ack_mask),
    .pending   (pending),
    .irq       (irq),
    .hit_vec   (hit_vec),
    .armed_vec (armed_vec),
    .en_vec    (en_vec)
);

// File: tb/sev_irq_gen_tb.sv
module sev_irq_gen_tb;

    localparam int NS = 8;
    localparam int DW = 16;
    localparam int NC = 8;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic signed [DW-1:0] sens [NC];
    logic signed [DW-1:0] func [NC];
    logic [NC*DW-1:0]    sens_flat;
    logic [NC*DW-1:0]    func_flat;
    logic                cfg_we = 1'b0;
    logic [2:0]          cfg_slot = '0;
    logic [1:0]          cfg_sel = '0;
    logic [DW-1:0]       cfg_wdata = '0;
    logic                ack_we = 1'b0;
    logic [NS-1:0]       ack_mask = '0;
    logic [NS-1:0]       pending;
    logic                irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    int mmode [NS];
    int mtyp  [NS];
    int midx  [NS];
    int mlo   [NS];
    int mhi   [NS];
    bit mprev [NS];
    bit mpend [NS];

    always #10 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NC; k++) begin
            sens_flat[k*DW +: DW] = sens[k];
            func_flat[k*DW +: DW] = func[k];
        end
    end

    sev_irq_gen #(.NUM_SLOTS(NS), .DW(DW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .sens_vals (sens_flat),
        .func_vals (func_flat),
        .cfg_we    (cfg_we),
        .cfg_slot  (cfg_slot),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ack_we    (ack_we),
        .ack_mask  (ack_mask),
        .pending   (pending),
        .irq       (irq)
    );

    function automatic bit mhit(int m, int v, int lo, int hi);
        case (m)
            1: return v < lo;
            2: return v > lo;
            3: return v == lo;
            4: return (v >= lo) && (v <= hi);
            5: return (v < lo) || (v > hi);
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NS; i++) begin
                mmode[i] = 0; mtyp[i] = 0; midx[i] = 0;
                mlo[i] = 0; mhi[i] = 0; mprev[i] = 0; mpend[i] = 0;
            end
        end else begin
            for (int i = 0; i < NS; i++) begin
                int v;
                bit h;
                v = (mtyp[i] != 0) ? int'(func[midx[i]]) : int'(sens[midx[i]]);
                h = mhit(mmode[i], v, mlo[i], mhi[i]);
                if (ack_we && ack_mask[i]) mpend[i] = 0;
                if (h && !mprev[i]) mpend[i] = 1;
                mprev[i] = h;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: begin
                        mmode[cfg_slot] = int'(cfg_wdata[2:0]);
                        mtyp[cfg_slot]  = int'(cfg_wdata[3]);
                        midx[cfg_slot]  = int'(cfg_wdata[6:4]);
                    end
                    2'd1: mlo[cfg_slot] = int'(signed'(cfg_wdata));
                    2'd2: mhi[cfg_slot] = int'(signed'(cfg_wdata));
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        logic [NS-1:0] ep;
        logic          ei;
        @(negedge clk);
        ei = 1'b0;
        for (int i = 0; i < NS; i++) begin
            ep[i] = mpend[i];
            if (mpend[i] && mmode[i] >= 1 && mmode[i] <= 5) ei = 1'b1;
        end
        chk("R6 pending vs model", 32'(pending), 32'(ep));
        chk("R9 irq vs model", 32'(irq), 32'(ei));
    endtask

    task automatic cfg(int slot, int sel, int data);
        cfg_we = 1'b1; cfg_slot = 3'(slot); cfg_sel = 2'(sel); cfg_wdata = DW'(data);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic ctl(int slot, int mode, int typ, int idx);
        cfg(slot, 0, (idx << 4) | (typ << 3) | mode);
    endtask

    task automatic ack(logic [NS-1:0] m);
        ack_we = 1'b1; ack_mask = m;
        step();
        ack_we = 1'b0; ack_mask = '0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NC; k++) begin sens[k] = '0; func[k] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        step();
        chk("R1 pending after reset", 32'(pending), 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'h0);

        // slot 0: sensor 2 below 100
        sens[2] = 16'sd50;
        cfg(0, 1, 100);
        ctl(0, 1, 0, 2);
        chk("R2 no effect before write settles", 32'(pending[0]), 32'h0);
        step();
        chk("R3 less-than fires (R5 sensor source)", 32'(pending[0]), 32'h1);
        chk("R9 irq raised", 32'(irq), 32'h1);
        repeat (3) step();
        ack(8'h01);
        chk("R7 ack clears bit", 32'(pending[0]), 32'h0);
        repeat (3) step();
        chk("R6 held condition does not refire", 32'(pending[0]), 32'h0);

        // set and clear in the same cycle
        sens[2] = 16'sd200; step();
        sens[2] = 16'sd50;  step();
        chk("R6 new rise sets bit", 32'(pending[0]), 32'h1);
        sens[2] = 16'sd200; step();
        sens[2] = 16'sd50;  ack(8'h01);
        chk("R8 rise beats clear", 32'(pending[0]), 32'h1);
        ack(8'h01);
        chk("R7 plain ack on held condition", 32'(pending[0]), 32'h0);

        // slot 1: function 5 above -5, signed
        func[5] = -16'sd10;
        sens[5] = 16'sd100;
        cfg(1, 1, -5);
        ctl(1, 2, 1, 5);
        step(); step();
        chk("R5 sensor value ignored for function source", 32'(pending[1]), 32'h0);
        func[5] = 16'sd3; step();
        chk("R3 signed greater-than fires", 32'(pending[1]), 32'h1);

        // slot 2: sensor 7 equals 7
        sens[7] = 16'sd6;
        cfg(2, 1, 7);
        ctl(2, 3, 0, 7);
        step(); step();
        chk("R3 equal not met", 32'(pending[2]), 32'h0);
        sens[7] = 16'sd7; step();
        chk("R3 equal fires", 32'(pending[2]), 32'h1);

        // slot 3: sensor 0 inside [-20,20]
        sens[0] = 16'sd21;
        cfg(3, 1, -20);
        cfg(3, 2, 20);
        ctl(3, 4, 0, 0);
        step(); step();
        chk("R4 inside range above upper", 32'(pending[3]), 32'h0);
        sens[0] = 16'sd20; step();
        chk("R4 inside range includes upper", 32'(pending[3]), 32'h1);

        // slot 4: sensor 1 outside [0,10]
        sens[1] = 16'sd10;
        cfg(4, 1, 0);
        cfg(4, 2, 10);
        ctl(4, 5, 0, 1);
        step(); step();
        chk("R4 outside not met at bound", 32'(pending[4]), 32'h0);
        sens[1] = 16'sd11; step();
        chk("R4 outside above upper", 32'(pending[4]), 32'h1);
        ack(8'h10);
        sens[1] = 16'sd5;  step();
        sens[1] = -16'sd1; step();
        chk("R4 outside below lower", 32'(pending[4]), 32'h1);

        // ignored field
        ack(8'hFF);
        chk("R7 ack all", 32'(pending), 32'h0);
        sens[1] = 16'sd5;  step();
        sens[1] = 16'sd11; step();
        cfg(4, 3, 0);
        step();
        chk("R2 field 3 write leaves slot", 32'(pending), 32'h10);
        chk("R9 irq from active slot", 32'(irq), 32'h1);

        // disable
        ctl(4, 0, 0, 1);
        chk("R9 disabled slot keeps bit", 32'(pending), 32'h10);
        chk("R9 disabled slot masks irq", 32'(irq), 32'h0);
        ack(8'h10);
        sens[1] = 16'sd5;  step();
        sens[1] = 16'sd12; step();
        chk("R10 disabled slot never sets", 32'(pending[4]), 32'h0);
        ctl(5, 6, 0, 0);
        step(); step();
        chk("R10 reserved mode acts disabled", 32'(pending[5]), 32'h0);
        chk("R10 reserved mode no irq", 32'(irq), 32'h0);

        repeat (2) step();
        done = 1;
        summary();
        $finish;
    end

endmodule